// File: doc/BRIEF.md
# DMA Global Mode, Enable and Status Registers

This block is the shared register set of a multi-channel DMA controller that has 4, 8 or 12 channels. Software uses a 32-bit register port to set each channel's transfer mode and direction, and to choose which channels may raise the interrupt. Through the same port it reads each channel's activity state, its interrupt-pending flag and its error flag. The channel engines supply one-cycle done and error pulses and a live 2-bit activity code. The block returns the mode and direction of every channel and a single interrupt line.

Channels 0 to 7 and channels 8 to 11 are held in separate registers with their own bit placement. In every control field a mode value of 3 means "leave this channel's mode as it is". Software can therefore program one channel by writing 3 into the mode fields of all the others, with no read-modify-write. Pending and error flags are cleared by writing 1 to them. Writing back a value just read clears exactly the flags that were seen.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset every mode, direction, enable, pending and error bit is 0, every register reads 0 while channel states are 0, and `irq` is low.
- R2: A write to offset 0x00 updates channel c (0 to 7) one cycle later: mode from bits [4c+1:4c] (0 off, 1 chained, 2 single) and direction from bit 4c+2. Both appear on `ch_mode`/`ch_dir` and read back at the same positions.
- R3: A mode field written as 3 leaves that channel's mode unchanged, while the direction bit of the same field is still applied.
- R4: Offset 0x0C holds channels 8 to 11 in the same per-channel layout, indexed from channel minus 8. Writes there leave channels 0 to 7 untouched.
- R5: Offset 0x08 holds the interrupt enables: bit c for channels 0 to 7, and bit c+8 (bits 16 to 19) for channels 8 to 11. All other bits read 0.
- R6: A done pulse sets the channel's pending flag. An error pulse sets both its pending flag and its error flag. Each flag is visible in the cycle after the pulse.
- R7: Offset 0x10 shows, for channel c (0 to 7), pending at bit c, error at bit c+8 and the live activity code at bits [17+2c:16+2c].
- R8: Writing 1 to a pending or error bit of offset 0x10 or 0x18 clears it, and bits written 0 keep their value. Writing back a value that was read clears exactly the flags it showed.
- R9: If a set pulse and a write-1-clear hit the same flag in the same cycle, the flag stays set.
- R10: `irq` is high exactly when some channel has both its pending flag and its enable set. A pending flag on a disabled channel does not raise it.
- R11: Offset 0x18 carries pending, error and activity fields for channels 8 to 11 at the same positions as offset 0x10, indexed from channel minus 8.
- R12: Fields of channels that do not exist, offsets 0x04, 0x14 and any other offset read 0, and writes to offsets 0x04 and 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| ch_done | input | NUM_CH | One-cycle completion pulse per channel |
| ch_err | input | NUM_CH | One-cycle error pulse per channel |
| ch_state | input | 2*NUM_CH | Activity code per channel, 2 bits each |
| ch_mode | output | 2*NUM_CH | Mode per channel, 2 bits each |
| ch_dir | output | NUM_CH | Direction per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong internal state shows at the ports within one cycle of the event that caused it. A mode or direction bit that is lost or kept wrongly appears on `ch_mode`/`ch_dir` and in the readback right after the write. A pending flag that fails to set or clear shows first on `irq` and then in the status readback on the very next access. Mixing up the two channel groups shows as a field that lands in the wrong register, because each test writes patterns that differ per channel and per group.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   localparam int OFS_CTL0 = 'h00;
   localparam int OFS_CTL1 = 'h04;
   localparam int OFS_CTL2 = 'h08;
   localparam int OFS_CTL3 = 'h0C;
   localparam int OFS_STS0 = 'h10;
   localparam int OFS_STS1 = 'h14;
   localparam int OFS_STS2 = 'h18;

   localparam int GROUP_LANES = 8;   // channels per register group
   localparam int FIELD_W     = 4;   // control field stride
   localparam int DIR_POS     = 2;   // direction bit inside a field
   localparam int ERR_LSB     = 8;   // error flags in status word
   localparam int STATE_LSB   = 16;  // activity codes in status word
   localparam int HI_EN_SKIP  = 8;   // enable offset for upper group

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_CHAIN  = 2'd1,
      MODE_SINGLE = 2'd2,
      MODE_KEEP   = 2'd3
   } xfer_mode_e;

   function automatic int en_pos(input int ch);
      return (ch < GROUP_LANES) ? ch : ch + HI_EN_SKIP;
   endfunction
endpackage

// File: rtl/dmareg_ctl_bank.sv
module dmareg_ctl_bank
   import dmareg_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          wdata,
   output logic [2*LANES-1:0]   mode_o,
   output logic [LANES-1:0]     dir_o,
   output logic [31:0]          rd_o
);
   if (LANES < 1 || LANES > GROUP_LANES) begin : g_bad_lanes
      $error("dmareg_ctl_bank: LANES must be 1..8");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int FLSB = FIELD_W * k;
      xfer_mode_e mode_q;
      logic       dir_q;
      logic [1:0] new_mode;

      assign new_mode = wdata[FLSB +: 2];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= MODE_OFF;
            dir_q  <= 1'b0;
         end else if (wr_en) begin
            dir_q <= wdata[FLSB + DIR_POS];
            if (new_mode != MODE_KEEP)
               mode_q <= xfer_mode_e'(new_mode);
         end
      end

      assign mode_o[2*k +: 2] = mode_q;
      assign dir_o[k]         = dir_q;

      // R3: keep code leaves the mode untouched
      a_r3_keep_mode: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wdata[FLSB +: 2] == 2'b11) |=> $stable(mode_o[2*k +: 2]));
      // R2: direction follows the written bit
      a_r2_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> dir_o[k] == $past(wdata[FLSB + DIR_POS]));
      // R2: without a write the channel settings hold
      a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(mode_o[2*k +: 2]) && $stable(dir_o[k]));
   end

   always_comb begin
      rd_o = '0;
      for (int k = 0; k < LANES; k++) begin
         rd_o[FIELD_W*k +: 2]         = mode_o[2*k +: 2];
         rd_o[FIELD_W*k + DIR_POS]    = dir_o[k];
      end
   end
endmodule

// File: rtl/dmareg_stat_bank.sv
module dmareg_stat_bank
   import dmareg_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     done_i,
   input  logic [LANES-1:0]     err_i,
   input  logic [2*LANES-1:0]   state_i,
   input  logic                 clr_en,
   input  logic [31:0]          wdata,
   output logic [LANES-1:0]     pend_o,
   output logic [LANES-1:0]     errf_o,
   output logic [31:0]          rd_o
);
   if (LANES < 1 || LANES > GROUP_LANES) begin : g_bad_lanes
      $error("dmareg_stat_bank: LANES must be 1..8");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   logic [LANES-1:0] clr_pend, clr_err;
   logic [LANES-1:0] pend_q, err_q;

   assign clr_pend = clr_en ? wdata[0 +: LANES]       : '0;
   assign clr_err  = clr_en ? wdata[ERR_LSB +: LANES] : '0;

   // set terms are applied after the clear, so a set in the same cycle wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         err_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_pend) | done_i | err_i;
         err_q  <= (err_q  & ~clr_err)  | err_i;
      end
   end

   assign pend_o = pend_q;
   assign errf_o = err_q;

   always_comb begin
      rd_o = '0;
      rd_o[0 +: LANES]           = pend_q;
      rd_o[ERR_LSB +: LANES]     = err_q;
      rd_o[STATE_LSB +: 2*LANES] = state_i;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      // R6: done sets pending
      a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
         done_i[k] |=> pend_o[k]);
      // R6: error sets pending and error
      a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
         err_i[k] |=> pend_o[k] && errf_o[k]);
      // R8: write-1 without a set clears pending
      a_r8_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && wdata[k] && !done_i[k] && !err_i[k]) |=> !pend_o[k]);
      // R8: no clear and no set keeps the flag
      a_r8_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_en && !done_i[k] && !err_i[k]) |=> $stable(pend_o[k]));
      // R9: set wins over a same-cycle clear
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && wdata[ERR_LSB + k] && err_i[k]) |=> errf_o[k]);
   end
endmodule

// File: rtl/dmareg_irq_en.sv
module dmareg_irq_en
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic [NUM_CH-1:0] pend_i,
   output logic [31:0]       rd_o,
   output logic              irq_o
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   logic [NUM_CH-1:0] en_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_en
      localparam int POS = en_pos(c);
      always_ff @(posedge clk) begin
         if (!rst_n)     en_q[c] <= 1'b0;
         else if (wr_en) en_q[c] <= wdata[POS];
      end

      // R10: enabled pending channel drives the line
      a_r10_enabled_fires: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_i[c] && en_q[c]) |-> irq_o);
   end

   always_comb begin
      rd_o = '0;
      for (int c = 0; c < NUM_CH; c++) rd_o[en_pos(c)] = en_q[c];
   end

   assign irq_o = |(pend_i & en_q);

   // R10: no enable means no interrupt
   a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int ADDR_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic [NUM_CH-1:0]     ch_done,
   input  logic [NUM_CH-1:0]     ch_err,
   input  logic [2*NUM_CH-1:0]   ch_state,
   output logic [2*NUM_CH-1:0]   ch_mode,
   output logic [NUM_CH-1:0]     ch_dir,
   output logic                  irq
);
   localparam int LO_CH = (NUM_CH > GROUP_LANES) ? GROUP_LANES : NUM_CH;
   localparam int HI_CH = NUM_CH - LO_CH;

   if (NUM_CH != 4 && NUM_CH != 8 && NUM_CH != 12) begin : g_bad_ch
      $error("dma_glob_regs: NUM_CH must be 4, 8 or 12");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("dma_glob_regs: ADDR_W too small for the register map");
   end

   logic sel_ctl0, sel_ctl2, sel_ctl3, sel_sts0, sel_sts2;
   assign sel_ctl0 = reg_addr == ADDR_W'(OFS_CTL0);
   assign sel_ctl2 = reg_addr == ADDR_W'(OFS_CTL2);
   assign sel_ctl3 = reg_addr == ADDR_W'(OFS_CTL3);
   assign sel_sts0 = reg_addr == ADDR_W'(OFS_STS0);
   assign sel_sts2 = reg_addr == ADDR_W'(OFS_STS2);

   logic [31:0]       rd_ctl0, rd_ctl2, rd_ctl3, rd_sts0, rd_sts2;
   logic [NUM_CH-1:0] pend_all, errf_all;

   logic unused_errf;
   assign unused_errf = ^errf_all;

   dmareg_ctl_bank #(.LANES(LO_CH)) u_ctl_lo (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_ctl0), .wdata(reg_wdata),
      .mode_o(ch_mode[2*LO_CH-1:0]), .dir_o(ch_dir[LO_CH-1:0]), .rd_o(rd_ctl0));

   dmareg_stat_bank #(.LANES(LO_CH)) u_sts_lo (
      .clk(clk), .rst_n(rst_n),
      .done_i(ch_done[LO_CH-1:0]), .err_i(ch_err[LO_CH-1:0]),
      .state_i(ch_state[2*LO_CH-1:0]),
      .clr_en(reg_wr && sel_sts0), .wdata(reg_wdata),
      .pend_o(pend_all[LO_CH-1:0]), .errf_o(errf_all[LO_CH-1:0]), .rd_o(rd_sts0));

   if (HI_CH > 0) begin : g_hi
      dmareg_ctl_bank #(.LANES(HI_CH)) u_ctl_hi (
         .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_ctl3), .wdata(reg_wdata),
         .mode_o(ch_mode[2*NUM_CH-1:2*LO_CH]), .dir_o(ch_dir[NUM_CH-1:LO_CH]),
         .rd_o(rd_ctl3));

      dmareg_stat_bank #(.LANES(HI_CH)) u_sts_hi (
         .clk(clk), .rst_n(rst_n),
         .done_i(ch_done[NUM_CH-1:LO_CH]), .err_i(ch_err[NUM_CH-1:LO_CH]),
         .state_i(ch_state[2*NUM_CH-1:2*LO_CH]),
         .clr_en(reg_wr && sel_sts2), .wdata(reg_wdata),
         .pend_o(pend_all[NUM_CH-1:LO_CH]), .errf_o(errf_all[NUM_CH-1:LO_CH]),
         .rd_o(rd_sts2));
   end else begin : g_no_hi
      assign rd_ctl3 = '0;
      assign rd_sts2 = '0;
   end

   dmareg_irq_en #(.NUM_CH(NUM_CH)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_ctl2), .wdata(reg_wdata),
      .pend_i(pend_all), .rd_o(rd_ctl2), .irq_o(irq));

   always_comb begin
      if      (sel_ctl0) reg_rdata = rd_ctl0;
      else if (sel_ctl2) reg_rdata = rd_ctl2;
      else if (sel_ctl3) reg_rdata = rd_ctl3;
      else if (sel_sts0) reg_rdata = rd_sts0;
      else if (sel_sts2) reg_rdata = rd_sts2;
      else               reg_rdata = '0;
   end

   // R4: a lower-group write never disturbs the upper group and vice versa
   a_r4_groups_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel_ctl0) |=> $stable(ch_mode[2*NUM_CH-1:2*LO_CH]) || (HI_CH == 0));
   // R12: reserved offsets leave all channel settings alone
   a_r12_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !sel_ctl0 && !sel_ctl3) |=> $stable(ch_mode) && $stable(ch_dir));
endmodule

// File: tb/dma_glob_regs_test.sv
module dma_glob_regs_test;
   localparam int N = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  ch_done = '0;
   logic [N-1:0]  ch_err = '0;
   logic [2*N-1:0] ch_state = '0;
   logic [2*N-1:0] ch_mode;
   logic [N-1:0]  ch_dir;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dma_glob_regs #(.NUM_CH(N), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
      .ch_err(ch_err), .ch_state(ch_state), .ch_mode(ch_mode),
      .ch_dir(ch_dir), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [N-1:0] dn, input logic [N-1:0] er);
      @(negedge clk);
      ch_done = dn; ch_err = er;
      @(negedge clk);
      ch_done = '0; ch_err = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 'h40; a += 4) begin
         rd(8'(a), v);
         check("R1 reset readback", v, 32'h0);
      end
      check("R1 reset irq", {31'b0, irq}, 32'h0);
      check("R1 reset mode", {8'b0, ch_mode}, 32'h0);
   endtask

   task automatic t_ctl0();
      logic [31:0] v;
      wr(8'h00, 32'h0000_0025);
      rd(8'h00, v);
      check("R2 ctl0 readback", v, 32'h0000_0025);
      check("R2 ch_mode lo", {28'b0, ch_mode[3:0]}, 32'h9);
      check("R2 ch_dir lo", {30'b0, ch_dir[1:0]}, 32'h1);
   endtask

   task automatic t_keep();
      logic [31:0] v;
      wr(8'h00, 32'h3333_3373);
      rd(8'h00, v);
      check("R3 keep mode, dir applied", v, 32'h0000_0061);
      check("R3 ch_mode kept", {28'b0, ch_mode[3:0]}, 32'h9);
      check("R3 ch_dir updated", {30'b0, ch_dir[1:0]}, 32'h2);
   endtask

   task automatic t_ctl3();
      logic [31:0] v;
      wr(8'h0C, 32'hFFFF_0076);
      rd(8'h0C, v);
      check("R4 ctl3 readback", v, 32'h0000_0046);
      check("R4 ch8 mode", {30'b0, ch_mode[17:16]}, 32'h2);
      check("R4 ch8/9 dir", {30'b0, ch_dir[9:8]}, 32'h3);
      rd(8'h00, v);
      check("R4 ctl0 untouched", v, 32'h0000_0061);
   endtask

   task automatic t_ctl2();
      logic [31:0] v;
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v);
      check("R5 enable bits", v, 32'h000F_00FF);
      wr(8'h08, 32'h0001_0001);
      rd(8'h08, v);
      check("R5 enable ch0 ch8", v, 32'h0001_0001);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      pulse(12'h001, 12'h000);
      rd(8'h10, v);
      check("R6 done sets pending", v, 32'h0000_0001);
      check("R10 irq enabled ch0", {31'b0, irq}, 32'h1);
      pulse(12'h000, 12'h008);
      rd(8'h10, v);
      check("R6 err sets pending+error", v, 32'h0000_0809);
      wr(8'h10, 32'h0);
      rd(8'h10, v);
      check("R8 zero write keeps", v, 32'h0000_0809);
      wr(8'h10, 32'h0000_0809);
      rd(8'h10, v);
      check("R8 write-back clears", v, 32'h0);
      check("R10 irq after clear", {31'b0, irq}, 32'h0);
      pulse(12'h020, 12'h000);
      rd(8'h10, v);
      check("R10 disabled pending", v, 32'h0000_0020);
      check("R10 irq masked", {31'b0, irq}, 32'h0);
      wr(8'h10, 32'h0000_0020);
   endtask

   task automatic t_state();
      logic [31:0] v;
      @(negedge clk);
      ch_state = '0;
      ch_state[1:0]   = 2'd1;
      ch_state[15:14] = 2'd3;
      ch_state[17:16] = 2'd2;
      ch_state[23:22] = 2'd1;
      rd(8'h10, v);
      check("R7 status0 state", v, 32'hC001_0000);
      rd(8'h18, v);
      check("R11 status2 state", v, 32'h0042_0000);
      @(negedge clk);
      ch_state = '0;
   endtask

   task automatic t_sts2();
      logic [31:0] v;
      pulse(12'h000, 12'h200);
      rd(8'h18, v);
      check("R11 ch9 error", v, 32'h0000_0202);
      check("R10 ch9 disabled", {31'b0, irq}, 32'h0);
      pulse(12'h100, 12'h000);
      rd(8'h18, v);
      check("R11 ch8 pending", v, 32'h0000_0203);
      check("R10 ch8 enabled irq", {31'b0, irq}, 32'h1);
      wr(8'h18, 32'h0000_0101);
      rd(8'h18, v);
      check("R8 partial clear status2", v, 32'h0000_0202);
      wr(8'h18, 32'h0000_0202);
      rd(8'h18, v);
      check("R8 clear status2", v, 32'h0);
      rd(8'h10, v);
      check("R11 status0 untouched", v, 32'h0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      pulse(12'h004, 12'h000);
      @(negedge clk);
      reg_addr = 8'h10; reg_wdata = 32'h0000_0004; reg_wr = 1'b1; ch_done = 12'h004;
      @(negedge clk);
      reg_wr = 1'b0; ch_done = '0;
      rd(8'h10, v);
      check("R9 done beats clear", v, 32'h0000_0004);
      @(negedge clk);
      reg_addr = 8'h10; reg_wdata = 32'h0000_0404; reg_wr = 1'b1; ch_err = 12'h004;
      @(negedge clk);
      reg_wr = 1'b0; ch_err = '0;
      rd(8'h10, v);
      check("R9 error beats clear", v, 32'h0000_0404);
      wr(8'h10, 32'h0000_0404);
      rd(8'h10, v);
      check("R9 clears afterwards", v, 32'h0);
   endtask

   task automatic t_unused();
      logic [31:0] v;
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h04, v);
      check("R12 ctl1 reads 0", v, 32'h0);
      rd(8'h14, v);
      check("R12 sts1 reads 0", v, 32'h0);
      rd(8'h20, v);
      check("R12 other offset 0", v, 32'h0);
      rd(8'h00, v);
      check("R12 ctl0 unchanged", v, 32'h0000_0061);
      rd(8'h0C, v);
      check("R12 ctl3 upper 0", v, 32'h0000_0046);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl0();
      t_keep();
      t_ctl3();
      t_ctl2();
      t_flags();
      t_state();
      t_sts2();
      t_race();
      t_unused();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule